// File: doc/BRIEF.md
# Half-Word Masked-Write GPIO Register Bank

This block is the register file of a 32-pin general-purpose I/O port. It sits behind a simple single-cycle register bus. It holds the per-pin control state: output level, pin direction, interrupt enable and mask, trigger type, trigger polarity, both-edge select and debounce enable. That state drives the pads and a separate interrupt detector. The bank also offers read-only words: the interrupt status and raw status coming back from the detector, the sampled pin levels, and a fixed version code.

Every 32-bit control register is split into two 16-bit halves at consecutive word addresses. A bus write to a half uses its upper 16 bits as a per-bit write enable for the lower 16 bits. Software can therefore set or clear any group of pins with one write, without reading the register first, and two agents changing different pins of the same register cannot overwrite each other. An end-of-interrupt pair of halves uses the same encoding. It stores nothing and instead emits a one-cycle clear pulse for each enabled bit.

Top module: `gpio_halfword_bank`

## Requirements
- R1: After reset, every stored register is zero, `pin_oe`, `pin_out`, all interrupt control outputs and `eoi_pulse` are zero, and `bus_rdata` is zero.
- R2: On a write to a split half, stored bit k takes `bus_wdata[k]` only when `bus_wdata[16+k]` is 1; every other stored bit of that half keeps its value.
- R3: Stored bits 0..15 of a split register are at its base address and bits 16..31 at base+4. A read of either half returns those 16 bits in `bus_rdata[15:0]` with `bus_rdata[31:16]` zero.
- R4: The split register base addresses (byte addresses, word aligned) are: output level 0x00, direction 0x08, interrupt enable 0x10, interrupt mask 0x18, trigger type 0x20, polarity 0x28, both-edge 0x30, debounce 0x38. Each drives its own output port and a write to one leaves all the others unchanged.
- R5: Reads of 0x50, 0x58 and 0x70 return the full 32-bit `irq_status_in`, `irq_raw_in` and `pin_in` respectively.
- R6: A read of 0x78 returns 0x01000C2B.
- R7: `pin_oe` equals the direction register (1 = output). `pin_out` carries the output level register only on pins whose direction bit is 1 and is 0 on input pins.
- R8: Writes to 0x50, 0x58, 0x70, 0x78 or to any unmapped address change no stored state and no output. Reads of unmapped addresses, including 0x40, return zero.
- R9: A write to the end-of-interrupt halves (0x60 for pins 0..15, 0x64 for pins 16..31) raises `eoi_pulse` bit k of that half for exactly one cycle, the cycle after the write, when both data bit k and enable bit 16+k are 1. Nothing is stored, and reads of 0x60 and 0x64 return zero.
- R10: `bus_rdata` is registered. It shows the addressed word in the cycle after a read access and holds that value until the next read, unaffected by writes or idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_acc | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data; [31:16] are the bit enables for split halves |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Sampled pin levels |
| irq_status_in | input | 32 | Masked interrupt status from the detector |
| irq_raw_in | input | 32 | Raw interrupt status from the detector |
| pin_out | output | 32 | Output level to the pads, gated by direction |
| pin_oe | output | 32 | Output enable per pin |
| irq_en | output | 32 | Interrupt enable per pin |
| irq_mask | output | 32 | Interrupt mask per pin |
| irq_type | output | 32 | Trigger type per pin |
| irq_pol | output | 32 | Trigger polarity per pin |
| irq_both | output | 32 | Both-edge select per pin |
| deb_en | output | 32 | Debounce enable per pin |
| eoi_pulse | output | 32 | One-cycle interrupt clear pulse per pin |

## Verification
The bench first writes a half with only some enable bits set, then clears a single bit with a zero-data write. A design that ignored the enable half would wipe the neighbouring pins, and one that used the enables inverted would change the wrong bits. Every stored register receives a distinct pattern in both halves. This catches a decode that aliases two registers or swaps the halves, as well as a readback that leaks the enables into the upper 16 bits. The bench writes all ones to the read-only and unmapped addresses, writes the end-of-interrupt pair and reads it back, and keeps the bus idle after a read. A bank that stored these writes, lengthened or lost the clear pulse, or let the read register drift would show a miscompare on a later read or on the output ports.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int PINS    = 32;
  localparam int HALF    = PINS / 2;
  localparam int ADDR_W  = 8;
  localparam int WORD_W  = ADDR_W - 2;
  localparam int NSTORE  = 8;

  typedef enum logic [2:0] {
    RG_DOUT  = 3'd0,
    RG_DIR   = 3'd1,
    RG_IEN   = 3'd2,
    RG_IMASK = 3'd3,
    RG_TTYPE = 3'd4,
    RG_POL   = 3'd5,
    RG_BOTH  = 3'd6,
    RG_DEB   = 3'd7
  } store_idx_e;

  localparam logic [PINS-1:0]   VERSION_WORD = 32'h0100_0C2B;
  localparam logic [ADDR_W-1:0] EOI_BASE  = 8'h60;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h50;
  localparam logic [ADDR_W-1:0] RAW_ADDR  = 8'h58;
  localparam logic [ADDR_W-1:0] PIN_ADDR  = 8'h70;
  localparam logic [ADDR_W-1:0] VER_ADDR  = 8'h78;

  // Word index of the low half of a stored split register (8 bytes apart).
  function automatic logic [WORD_W-1:0] store_word(input int idx);
    return WORD_W'(idx * 2);
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2];
  endfunction

  // Enable-masked merge of one 16-bit half.
  function automatic logic [HALF-1:0] masked_merge(input logic [HALF-1:0] old,
                                                   input logic [PINS-1:0] wd);
    return (old & ~wd[PINS-1:HALF]) | (wd[HALF-1:0] & wd[PINS-1:HALF]);
  endfunction

  // Bits that are both requested and enabled (used by the clear pulse).
  function automatic logic [HALF-1:0] enabled_ones(input logic [PINS-1:0] wd);
    return wd[HALF-1:0] & wd[PINS-1:HALF];
  endfunction

  function automatic logic [PINS-1:0] half_to_word(input logic [HALF-1:0] h);
    return {{(PINS-HALF){1'b0}}, h};
  endfunction
endpackage

// File: rtl/gpio_split_reg.sv
`timescale 1ns/1ps
module gpio_split_reg
  import gpio_bank_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_lo,
  input  logic            we_hi,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] q
);
  logic [1:0] we;
  assign we = {we_hi, we_lo};

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF-1:0] bits;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bits <= '0;
        else if (we[h])
          bits <= masked_merge(bits, wdata);
      end
      assign q[h*HALF +: HALF] = bits;
    end
  endgenerate

  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_lo || we_hi) |=> $stable(q)); // R2

  AST_LO_UNENABLED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo |=> ((q[HALF-1:0] & ~$past(wdata[PINS-1:HALF])) ==
               ($past(q[HALF-1:0]) & ~$past(wdata[PINS-1:HALF])))); // R2

  AST_HI_UNENABLED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi |=> ((q[PINS-1:HALF] & ~$past(wdata[PINS-1:HALF])) ==
               ($past(q[PINS-1:HALF]) & ~$past(wdata[PINS-1:HALF])))); // R2
endmodule

// File: rtl/gpio_bank_decode.sv
`timescale 1ns/1ps
module gpio_bank_decode
  import gpio_bank_pkg::*;
(
  input  logic              bus_acc,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NSTORE-1:0] lo_hit,
  output logic [NSTORE-1:0] hi_hit,
  output logic [NSTORE-1:0] st_we_lo,
  output logic [NSTORE-1:0] st_we_hi,
  output logic              eoi_we_lo,
  output logic              eoi_we_hi,
  output logic              stat_hit,
  output logic              raw_hit,
  output logic              pin_hit,
  output logic              ver_hit,
  output logic              mapped
);
  logic [WORD_W-1:0] word;
  logic              wr_cyc;
  logic              eoi_lo_hit;
  logic              eoi_hi_hit;

  assign word   = word_of(bus_addr);
  assign wr_cyc = bus_acc && bus_wr;

  generate
    for (genvar g = 0; g < NSTORE; g++) begin : g_store
      assign lo_hit[g]   = (word == store_word(g));
      assign hi_hit[g]   = (word == store_word(g) + WORD_W'(1));
      assign st_we_lo[g] = wr_cyc && lo_hit[g];
      assign st_we_hi[g] = wr_cyc && hi_hit[g];
    end
  endgenerate

  assign eoi_lo_hit = (word == word_of(EOI_BASE));
  assign eoi_hi_hit = (word == word_of(EOI_BASE) + WORD_W'(1));
  assign eoi_we_lo  = wr_cyc && eoi_lo_hit;
  assign eoi_we_hi  = wr_cyc && eoi_hi_hit;

  assign stat_hit = (word == word_of(STAT_ADDR));
  assign raw_hit  = (word == word_of(RAW_ADDR));
  assign pin_hit  = (word == word_of(PIN_ADDR));
  assign ver_hit  = (word == word_of(VER_ADDR));

  assign mapped = (|lo_hit) || (|hi_hit) || eoi_lo_hit || eoi_hi_hit ||
                  stat_hit || raw_hit || pin_hit || ver_hit;
endmodule

// File: rtl/gpio_bank_rdmux.sv
`timescale 1ns/1ps
module gpio_bank_rdmux
  import gpio_bank_pkg::*;
(
  input  logic [NSTORE-1:0][PINS-1:0] st_q,
  input  logic [NSTORE-1:0]           lo_hit,
  input  logic [NSTORE-1:0]           hi_hit,
  input  logic                        stat_hit,
  input  logic                        raw_hit,
  input  logic                        pin_hit,
  input  logic                        ver_hit,
  input  logic [PINS-1:0]             irq_status_in,
  input  logic [PINS-1:0]             irq_raw_in,
  input  logic [PINS-1:0]             pin_in,
  output logic [PINS-1:0]             rd_word
);
  logic [NSTORE-1:0][PINS-1:0] term;

  generate
    for (genvar g = 0; g < NSTORE; g++) begin : g_term
      assign term[g] = (lo_hit[g] ? half_to_word(st_q[g][HALF-1:0])    : '0) |
                       (hi_hit[g] ? half_to_word(st_q[g][PINS-1:HALF]) : '0);
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NSTORE; i++)
      rd_word = rd_word | term[i];
    if (stat_hit) rd_word = rd_word | irq_status_in;
    if (raw_hit)  rd_word = rd_word | irq_raw_in;
    if (pin_hit)  rd_word = rd_word | pin_in;
    if (ver_hit)  rd_word = rd_word | VERSION_WORD;
  end
endmodule

// File: rtl/gpio_halfword_bank.sv
`timescale 1ns/1ps
module gpio_halfword_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_acc,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   irq_status_in,
  input  logic [PINS-1:0]   irq_raw_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   irq_en,
  output logic [PINS-1:0]   irq_mask,
  output logic [PINS-1:0]   irq_type,
  output logic [PINS-1:0]   irq_pol,
  output logic [PINS-1:0]   irq_both,
  output logic [PINS-1:0]   deb_en,
  output logic [PINS-1:0]   eoi_pulse
);
  logic [NSTORE-1:0]           lo_hit, hi_hit, st_we_lo, st_we_hi;
  logic                        eoi_we_lo, eoi_we_hi;
  logic                        stat_hit, raw_hit, pin_hit, ver_hit, mapped;
  logic [NSTORE-1:0][PINS-1:0] st_q;
  logic [PINS-1:0]             rd_word;
  logic                        rd_cyc;
  logic                        eoi_any_we;
  logic [PINS-1:0]             eoi_next;

  gpio_bank_decode u_dec (
    .bus_acc   (bus_acc),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .lo_hit    (lo_hit),
    .hi_hit    (hi_hit),
    .st_we_lo  (st_we_lo),
    .st_we_hi  (st_we_hi),
    .eoi_we_lo (eoi_we_lo),
    .eoi_we_hi (eoi_we_hi),
    .stat_hit  (stat_hit),
    .raw_hit   (raw_hit),
    .pin_hit   (pin_hit),
    .ver_hit   (ver_hit),
    .mapped    (mapped)
  );

  generate
    for (genvar g = 0; g < NSTORE; g++) begin : g_reg
      gpio_split_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we_lo (st_we_lo[g]),
        .we_hi (st_we_hi[g]),
        .wdata (bus_wdata),
        .q     (st_q[g])
      );
    end
  endgenerate

  gpio_bank_rdmux u_rd (
    .st_q          (st_q),
    .lo_hit        (lo_hit),
    .hi_hit        (hi_hit),
    .stat_hit      (stat_hit),
    .raw_hit       (raw_hit),
    .pin_hit       (pin_hit),
    .ver_hit       (ver_hit),
    .irq_status_in (irq_status_in),
    .irq_raw_in    (irq_raw_in),
    .pin_in        (pin_in),
    .rd_word       (rd_word)
  );

  assign rd_cyc = bus_acc && !bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (rd_cyc)
      bus_rdata <= rd_word;
  end

  assign eoi_any_we = eoi_we_lo || eoi_we_hi;
  assign eoi_next = {(eoi_we_hi ? enabled_ones(bus_wdata) : {HALF{1'b0}}),
                     (eoi_we_lo ? enabled_ones(bus_wdata) : {HALF{1'b0}})};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      eoi_pulse <= '0;
    else
      eoi_pulse <= eoi_next;
  end

  assign pin_oe   = st_q[RG_DIR];
  assign pin_out  = st_q[RG_DOUT] & st_q[RG_DIR];
  assign irq_en   = st_q[RG_IEN];
  assign irq_mask = st_q[RG_IMASK];
  assign irq_type = st_q[RG_TTYPE];
  assign irq_pol  = st_q[RG_POL];
  assign irq_both = st_q[RG_BOTH];
  assign deb_en   = st_q[RG_DEB];

  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && ver_hit) |=> (bus_rdata == VERSION_WORD)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && !mapped) |=> (bus_rdata == '0)); // R8

  AST_EOI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_any_we |=> (eoi_pulse == '0)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cyc |=> $stable(bus_rdata)); // R10

  AST_DRIVE_ONLY_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0)); // R7
endmodule

// File: tb/gpio_halfword_bank_tb.sv
`timescale 1ns/1ps
module gpio_halfword_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_acc = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0, irq_status_in = '0, irq_raw_in = '0;
  logic [31:0] pin_out, pin_oe, irq_en, irq_mask, irq_type, irq_pol, irq_both, deb_en, eoi_pulse;

  always #10 clk = ~clk;

  gpio_halfword_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_acc(bus_acc), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq_status_in(irq_status_in), .irq_raw_in(irq_raw_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_en(irq_en), .irq_mask(irq_mask),
    .irq_type(irq_type), .irq_pol(irq_pol), .irq_both(irq_both),
    .deb_en(deb_en), .eoi_pulse(eoi_pulse)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bench-side model of the eight stored registers.
  logic [31:0] mdl [8];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pend = 1'b0;

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Model of an enabled half write, written bit by bit.
  function automatic logic [15:0] apply_half(input logic [15:0] cur, input logic [31:0] wd);
    logic [15:0] r = cur;
    for (int k = 0; k < 16; k++)
      if (wd[16+k]) r[k] = wd[k];
    return r;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_acc = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_acc = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic model_write(input int idx, input bit hi, input logic [31:0] d);
    if (hi) mdl[idx][31:16] = apply_half(mdl[idx][31:16], d);
    else    mdl[idx][15:0]  = apply_half(mdl[idx][15:0], d);
    bus_write(8'(idx*8 + (hi ? 4 : 0)), d);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_acc = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_acc = 1'b0;
  endtask

  task automatic read_store(input int idx, input string tag);
    bus_read(8'(idx*8),     {16'h0, mdl[idx][15:0]},  tag);
    bus_read(8'(idx*8 + 4), {16'h0, mdl[idx][31:16]}, tag);
  endtask

  // Monitor: a read launched before this edge is compared at the next falling edge.
  always @(posedge clk) rd_pend <= bus_acc && !bus_wr;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard read without expected item actual=%08h expected=none", bus_rdata);
      end else begin
        check32(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20ns * 100000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check32("R1 pin_oe", pin_oe, 32'h0);
    check32("R1 pin_out", pin_out, 32'h0);
    check32("R1 irq_en", irq_en, 32'h0);
    check32("R1 deb_en", deb_en, 32'h0);
    check32("R1 eoi_pulse", eoi_pulse, 32'h0);
    check32("R1 rdata", bus_rdata, 32'h0);
    read_store(1, "R1 dir read");

    // R6 version
    bus_read(8'h78, 32'h0100_0C2B, "R6 version");

    // R2 R7 partial enable writes
    model_write(1, 0, 32'hFFFF_00FF);
    check32("R7 pin_oe low", pin_oe, 32'h0000_00FF);
    model_write(0, 0, 32'h00FF_00AA);
    check32("R7 pin_out", pin_out, 32'h0000_00AA);
    model_write(0, 0, 32'h0F00_0F55);
    check32("R2 R7 pin_out input pins gated", pin_out, mdl[0] & mdl[1]);
    read_store(0, "R2 dout read");
    model_write(0, 0, 32'h0002_0000);
    read_store(0, "R2 single bit clear");
    check32("R2 expected value", mdl[0], 32'h0000_0FA8);

    // R3 upper half
    model_write(0, 1, 32'hFFFF_1234);
    model_write(1, 1, 32'hFFFF_FFFF);
    check32("R3 pin_oe", pin_oe, 32'hFFFF_00FF);
    check32("R3 R7 pin_out", pin_out, 32'h1234_00A8);
    read_store(0, "R3 dout halves");
    read_store(1, "R3 dir halves");

    // R4 distinct registers
    for (int i = 2; i < 8; i++) begin
      model_write(i, 0, 32'hFFFF_0000 | 32'(16'h0101 * i));
      model_write(i, 1, 32'hFFFF_0000 | 32'(16'hA000 + i));
    end
    check32("R4 irq_en",   irq_en,   mdl[2]);
    check32("R4 irq_mask", irq_mask, mdl[3]);
    check32("R4 irq_type", irq_type, mdl[4]);
    check32("R4 irq_pol",  irq_pol,  mdl[5]);
    check32("R4 irq_both", irq_both, mdl[6]);
    check32("R4 deb_en",   deb_en,   mdl[7]);
    check32("R4 irq_pol value", irq_pol, 32'hA005_0505);
    for (int i = 0; i < 8; i++) read_store(i, "R4 readback");

    // R5 read-only inputs
    pin_in = 32'hDEAD_BEEF; irq_status_in = 32'h1357_9BDF; irq_raw_in = 32'h8642_0ACE;
    bus_read(8'h50, 32'h1357_9BDF, "R5 status");
    bus_read(8'h58, 32'h8642_0ACE, "R5 raw");
    bus_read(8'h70, 32'hDEAD_BEEF, "R5 pins");

    // R8 ignored writes, unmapped reads
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_write(8'h78, 32'hFFFF_FFFF);
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_write(8'h7C, 32'hFFFF_FFFF);
    bus_read(8'h40, 32'h0, "R8 unmapped 0x40");
    bus_read(8'h7C, 32'h0, "R8 unmapped 0x7C");
    bus_read(8'h78, 32'h0100_0C2B, "R8 version intact");
    bus_read(8'h50, 32'h1357_9BDF, "R8 status intact");
    check32("R8 pin_oe intact", pin_oe, mdl[1]);
    check32("R8 irq_en intact", irq_en, mdl[2]);
    for (int i = 0; i < 8; i++) read_store(i, "R8 stores intact");

    // R9 clear pulse
    bus_write(8'h60, 32'h00F0_00FF);
    check32("R9 pulse low half", eoi_pulse, 32'h0000_00F0);
    @(negedge clk);
    check32("R9 pulse one cycle", eoi_pulse, 32'h0);
    bus_write(8'h64, 32'h8001_8001);
    check32("R9 pulse high half", eoi_pulse, 32'h8001_0000);
    @(negedge clk);
    check32("R9 pulse gone", eoi_pulse, 32'h0);
    bus_read(8'h60, 32'h0, "R9 read low zero");
    bus_read(8'h64, 32'h0, "R9 read high zero");
    check32("R9 irq_en untouched", irq_en, mdl[2]);

    // R10 rdata hold
    bus_read(8'h78, 32'h0100_0C2B, "R10 launch read");
    repeat (3) @(negedge clk);
    check32("R10 hold idle", bus_rdata, 32'h0100_0C2B);
    model_write(3, 0, 32'hFFFF_5A5A);
    check32("R10 hold across write", bus_rdata, 32'h0100_0C2B);
    read_store(3, "R10 new read");

    repeat (2) @(negedge clk);
    check32("scoreboard drained", 32'(exp_q.size()), 32'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule